// File: doc/BRIEF.md
# Palette DAC Host Register Port

This block is the host-facing register port of a palette-based video DAC. The host reaches it through four directly addressed ports, selected on a two-bit port code. The first port is a shared address register. The second is a data window onto a few indirect control registers, chosen by the current address. The third is a colour table data port. The fourth is a cursor image data port, which this block accepts and discards.

Colour table entries are loaded as three back-to-back component writes. A small sequencer stages the first two components. On the third write it commits all three, plus a fixed opaque alpha, to the table entry at the current address. The shared address then steps to the next entry, so a host can stream a whole palette after one address write.

The indirect control registers hold the cursor position, a double-buffer control byte and a miscellaneous control byte. The block decodes the miscellaneous control byte into a pixel depth and a pixel clock divisor. Two sticky flags report an invalid depth code and a write to an indirect index that does not exist. Any table entry can be read combinationally by index.

Top module: `dac_host_port`

## Requirements
- R1: After reset, the address is 0, both cursor position bytes and the double-buffer byte are 0, the depth code is 0 (8 bpp), the clock divisor is 2, and both error flags are 0.
- R2: A write with port code 0 loads the address from the data bus and returns the component sequencer to its first phase. Any partly entered colour is discarded, so the next three colour writes form a complete entry.
- R3: The third consecutive write with port code 2 stores an entry at the current address. On `rd_color`, bits [31:24] read 0xFF, [23:16] the first component, [15:8] the second and [7:0] the third. The entry is readable in the cycle after the third write.
- R4: The address is unchanged after the first and second colour writes and increments by one after the third.
- R5: The address is 8 bits wide and wraps from 0xFF to 0x00 when it auto-increments.
- R6: A write with port code 1 updates the indirect register named by the address: 0x10 cursor position high, 0x11 cursor position low, 0x20 miscellaneous control, 0x21 double-buffer control. The address itself is left unchanged.
- R7: Miscellaneous control bits [3:2] give the depth code. Code 0 reads as 8 bpp, 1 as 16 bpp and 2 as 32 bpp on `depth_bpp`. Code 3 reads as 0.
- R8: The clock divisor equals 1 shifted left by (miscellaneous control bits [7:6] + 1), giving 2, 4, 8 or 16.
- R9: Writing depth code 3 sets `depth_err`, which stays set until reset even after a valid code is written.
- R10: A port code 1 write while the address names no indirect register sets the sticky `index_err`. It changes no indirect register.
- R11: Writes with port code 3 (cursor data) change neither the address, nor the sequencer phase, nor any register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_port | input | 2 | Port code: 0 address, 1 indirect data, 2 colour data, 3 cursor data |
| wr_data | input | 8 | Write data |
| rd_index | input | 8 | Colour table read index |
| rd_color | output | 32 | Entry at `rd_index`: alpha, first, second, third component |
| dac_addr | output | 8 | Current shared address |
| cursor_hi | output | 8 | Cursor position high byte |
| cursor_lo | output | 8 | Cursor position low byte |
| dbuf_ctrl | output | 8 | Double-buffer control byte |
| depth_code | output | 2 | Raw depth code from control bits [3:2] |
| depth_bpp | output | 6 | Decoded bits per pixel, 0 when invalid |
| clk_div | output | 5 | Pixel clock divisor |
| depth_err | output | 1 | Sticky invalid depth code flag |
| index_err | output | 1 | Sticky unsupported indirect index flag |

## Verification
A sequencer phase that is wrong cannot be seen directly. It shows up as an address that steps after the wrong number of colour writes, or as components landing in the wrong byte lanes of a table entry. Both are visible in the cycle after the third colour write. An address that is loaded or advanced wrongly sends an entry to the wrong table slot or a control byte to the wrong indirect register. The readback of that slot or register exposes it one cycle later. A flag that fails to hold, or a stray write that disturbs state, is caught by rereading the outputs after a later valid write.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_IREG = 2'd1,
    PORT_CLUT = 2'd2,
    PORT_CURS = 2'd3
  } dac_port_e;

  localparam logic [7:0] IX_CURS_HI = 8'h10;
  localparam logic [7:0] IX_CURS_LO = 8'h11;
  localparam logic [7:0] IX_MISC    = 8'h20;
  localparam logic [7:0] IX_DBUF    = 8'h21;

  localparam logic [1:0] DEPTH_BAD  = 2'd3;
endpackage

// File: rtl/dac_seq.sv
module dac_seq #(
  parameter int DW    = 8,
  parameter int NCOMP = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_we,
  input  logic                clut_we,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       addr_q,
  output logic                commit,
  output logic [NCOMP*DW-1:0] commit_data
);
  localparam int IW = (NCOMP > 1) ? $clog2(NCOMP) : 1;
  localparam logic [IW-1:0] LAST = IW'(NCOMP - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] addr_d;
  logic [DW-1:0] stage_q [NCOMP-1];

  always_comb begin
    addr_d = addr_q;
    idx_d  = idx_q;
    commit = 1'b0;
    if (addr_we) begin
      addr_d = wdata;
      idx_d  = '0;
    end else if (clut_we) begin
      if (idx_q == LAST) begin
        commit = 1'b1;
        addr_d = DW'(addr_q + 1'b1);
        idx_d  = '0;
      end else begin
        idx_d = IW'(idx_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else begin
      addr_q <= addr_d;
      idx_q  <= idx_d;
    end
  end

  for (genvar g = 0; g < NCOMP - 1; g++) begin : g_stage
    logic stage_en;
    assign stage_en = clut_we && !addr_we && (idx_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[g] <= '0;
      else if (stage_en) stage_q[g] <= wdata;
    end
    assign commit_data[(NCOMP-1-g)*DW +: DW] = stage_q[g];
  end
  assign commit_data[DW-1:0] = wdata;

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (addr_q == $past(wdata)) && (idx_q == '0));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> addr_q == DW'($past(addr_q) + 1'b1));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && !clut_we) |=> $stable(addr_q) && $stable(idx_q));
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
endmodule

// File: rtl/dac_palette.sv
module dac_palette #(
  parameter int DW    = 8,
  parameter int NCOMP = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [DW-1:0]           waddr,
  input  logic [NCOMP*DW-1:0]     wdata,
  input  logic [DW-1:0]           ridx,
  output logic [(NCOMP+1)*DW-1:0] rdata
);
  localparam int DEPTH = 2 ** DW;

  logic [NCOMP*DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = {{DW{1'b1}}, mem[ridx]};

  p_entry_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ireg_we,
  input  logic [DW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] curs_hi,
  output logic [DW-1:0] curs_lo,
  output logic [DW-1:0] dbuf,
  output logic [1:0]    depth_code,
  output logic [5:0]    depth_bpp,
  output logic [4:0]    clk_div,
  output logic          depth_err,
  output logic          index_err
);
  logic [DW-1:0] misc_q;
  logic hit_hi, hit_lo, hit_misc, hit_dbuf, hit_any;
  logic depth_err_d, index_err_d;

  assign hit_hi   = ireg_we && (sel == DW'(IX_CURS_HI));
  assign hit_lo   = ireg_we && (sel == DW'(IX_CURS_LO));
  assign hit_misc = ireg_we && (sel == DW'(IX_MISC));
  assign hit_dbuf = ireg_we && (sel == DW'(IX_DBUF));
  assign hit_any  = hit_hi || hit_lo || hit_misc || hit_dbuf;

  always_comb begin
    depth_err_d = depth_err;
    index_err_d = index_err;
    if (hit_misc && (wdata[3:2] == DEPTH_BAD)) depth_err_d = 1'b1;
    if (ireg_we && !hit_any)                   index_err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curs_hi   <= '0;
      curs_lo   <= '0;
      misc_q    <= '0;
      dbuf      <= '0;
      depth_err <= 1'b0;
      index_err <= 1'b0;
    end else begin
      if (hit_hi)   curs_hi <= wdata;
      if (hit_lo)   curs_lo <= wdata;
      if (hit_misc) misc_q  <= wdata;
      if (hit_dbuf) dbuf    <= wdata;
      depth_err <= depth_err_d;
      index_err <= index_err_d;
    end
  end

  assign depth_code = misc_q[3:2];

  always_comb begin
    case (depth_code)
      2'd0:    depth_bpp = 6'd8;
      2'd1:    depth_bpp = 6'd16;
      2'd2:    depth_bpp = 6'd32;
      default: depth_bpp = 6'd0;
    endcase
  end

  // widen before adding so code 3 shifts by 4, not by 0
  assign clk_div = 5'd1 << ({1'b0, misc_q[7:6]} + 3'd1);

  p_bad_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ireg_we && !hit_any) |=> index_err && $stable(curs_hi) && $stable(curs_lo)
                              && $stable(misc_q) && $stable(dbuf));
  p_index_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    index_err |=> index_err);
  p_depth_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_misc && wdata[3:2] == DEPTH_BAD) |=> depth_err);
  p_depth_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_err |=> depth_err);
endmodule

// File: rtl/dac_host_port.sv
module dac_host_port
  import dac_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NCOMP = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_port,
  input  logic [DW-1:0]           wr_data,
  input  logic [DW-1:0]           rd_index,
  output logic [(NCOMP+1)*DW-1:0] rd_color,
  output logic [DW-1:0]           dac_addr,
  output logic [DW-1:0]           cursor_hi,
  output logic [DW-1:0]           cursor_lo,
  output logic [DW-1:0]           dbuf_ctrl,
  output logic [1:0]              depth_code,
  output logic [5:0]              depth_bpp,
  output logic [4:0]              clk_div,
  output logic                    depth_err,
  output logic                    index_err
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dac_port_e port;
  logic addr_we, ireg_we, clut_we, curs_we;
  logic commit;
  logic [NCOMP*DW-1:0] commit_data;

  assign port    = dac_port_e'(wr_port);
  assign addr_we = wr_en && (port == PORT_ADDR);
  assign ireg_we = wr_en && (port == PORT_IREG);
  assign clut_we = wr_en && (port == PORT_CLUT);
  assign curs_we = wr_en && (port == PORT_CURS);

  dac_seq #(.DW(DW), .NCOMP(NCOMP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .addr_we     (addr_we),
    .clut_we     (clut_we),
    .wdata       (wr_data),
    .addr_q      (dac_addr),
    .commit      (commit),
    .commit_data (commit_data)
  );

  dac_palette #(.DW(DW), .NCOMP(NCOMP)) u_pal (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (commit),
    .waddr (dac_addr),
    .wdata (commit_data),
    .ridx  (rd_index),
    .rdata (rd_color)
  );

  dac_ctrl_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ireg_we    (ireg_we),
    .sel        (dac_addr),
    .wdata      (wr_data),
    .curs_hi    (cursor_hi),
    .curs_lo    (cursor_lo),
    .dbuf       (dbuf_ctrl),
    .depth_code (depth_code),
    .depth_bpp  (depth_bpp),
    .clk_div    (clk_div),
    .depth_err  (depth_err),
    .index_err  (index_err)
  );

  p_curs_ignored_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    curs_we |=> $stable(dac_addr) && $stable(cursor_hi) && $stable(cursor_lo)
                && $stable(dbuf_ctrl) && $stable(depth_code)
                && $stable(depth_err) && $stable(index_err));
  p_ireg_keeps_addr_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ireg_we |=> $stable(dac_addr));
endmodule

// File: tb/test_dac_host_port.sv
module test_dac_host_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_port;
  logic [7:0]  wr_data;
  logic [7:0]  rd_index;
  logic [31:0] rd_color;
  logic [7:0]  dac_addr, cursor_hi, cursor_lo, dbuf_ctrl;
  logic [1:0]  depth_code;
  logic [5:0]  depth_bpp;
  logic [4:0]  clk_div;
  logic        depth_err, index_err;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dac_host_port i_dac_host_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .rd_index(rd_index), .rd_color(rd_color),
    .dac_addr(dac_addr), .cursor_hi(cursor_hi), .cursor_lo(cursor_lo),
    .dbuf_ctrl(dbuf_ctrl), .depth_code(depth_code), .depth_bpp(depth_bpp),
    .clk_div(clk_div), .depth_err(depth_err), .index_err(index_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on the falling edge; outputs are settled at the next falling edge
  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic entry(input string req, input logic [7:0] idx, input logic [31:0] exp);
    rd_index = idx;
    #1;
    check(req, rd_color, exp);
  endtask

  task automatic t_reset;
    check("R1 addr", {24'h0, dac_addr}, 32'h0);
    check("R1 cursor_hi", {24'h0, cursor_hi}, 32'h0);
    check("R1 cursor_lo", {24'h0, cursor_lo}, 32'h0);
    check("R1 dbuf", {24'h0, dbuf_ctrl}, 32'h0);
    check("R1 bpp", {26'h0, depth_bpp}, 32'd8);
    check("R1 clk_div", {27'h0, clk_div}, 32'd2);
    check("R1 errors", {30'h0, depth_err, index_err}, 32'h0);
  endtask

  task automatic t_palette;
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h11);
    check("R4 addr after 1st", {24'h0, dac_addr}, 32'h05);
    wr(2'd2, 8'h22);
    check("R4 addr after 2nd", {24'h0, dac_addr}, 32'h05);
    wr(2'd2, 8'h33);
    check("R4 addr after 3rd", {24'h0, dac_addr}, 32'h06);
    entry("R3 entry 05", 8'h05, 32'hFF112233);
    wr(2'd2, 8'h44); wr(2'd2, 8'h55); wr(2'd2, 8'h66);
    entry("R3 entry 06", 8'h06, 32'hFF445566);
    check("R4 addr stream", {24'h0, dac_addr}, 32'h07);
  endtask

  task automatic t_restart;
    wr(2'd0, 8'h40);
    wr(2'd2, 8'hAA); wr(2'd2, 8'hBB);
    wr(2'd0, 8'h40);
    check("R2 addr reload", {24'h0, dac_addr}, 32'h40);
    wr(2'd2, 8'h01); wr(2'd2, 8'h02);
    check("R2 no early commit", {24'h0, dac_addr}, 32'h40);
    wr(2'd2, 8'h03);
    entry("R2 entry 40", 8'h40, 32'hFF010203);
    check("R2 addr after", {24'h0, dac_addr}, 32'h41);
  endtask

  task automatic t_wrap;
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h07); wr(2'd2, 8'h08); wr(2'd2, 8'h09);
    entry("R5 entry FF", 8'hFF, 32'hFF070809);
    check("R5 addr wrap", {24'h0, dac_addr}, 32'h00);
  endtask

  task automatic t_ireg;
    wr(2'd0, 8'h10); wr(2'd1, 8'h3C);
    check("R6 cursor_hi", {24'h0, cursor_hi}, 32'h3C);
    check("R6 addr kept", {24'h0, dac_addr}, 32'h10);
    wr(2'd0, 8'h11); wr(2'd1, 8'hC3);
    check("R6 cursor_lo", {24'h0, cursor_lo}, 32'hC3);
    wr(2'd0, 8'h21); wr(2'd1, 8'h5A);
    check("R6 dbuf", {24'h0, dbuf_ctrl}, 32'h5A);
    check("R6 cursor_hi kept", {24'h0, cursor_hi}, 32'h3C);
  endtask

  task automatic t_depth;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h44);
    check("R7 bpp16", {26'h0, depth_bpp}, 32'd16);
    check("R8 div4", {27'h0, clk_div}, 32'd4);
    wr(2'd1, 8'h88);
    check("R7 bpp32", {26'h0, depth_bpp}, 32'd32);
    check("R8 div8", {27'h0, clk_div}, 32'd8);
    wr(2'd1, 8'hC0);
    check("R7 bpp8", {26'h0, depth_bpp}, 32'd8);
    check("R8 div16", {27'h0, clk_div}, 32'd16);
    check("R9 no err on valid", {31'h0, depth_err}, 32'd0);
  endtask

  task automatic t_bad_depth;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h0C);
    check("R7 code3", {30'h0, depth_code}, 32'd3);
    check("R7 bpp0", {26'h0, depth_bpp}, 32'd0);
    check("R9 err set", {31'h0, depth_err}, 32'd1);
    wr(2'd1, 8'h00);
    check("R9 err sticky", {31'h0, depth_err}, 32'd1);
    check("R9 bpp restored", {26'h0, depth_bpp}, 32'd8);
    check("R8 div2", {27'h0, clk_div}, 32'd2);
  endtask

  task automatic t_bad_index;
    check("R10 clear before", {31'h0, index_err}, 32'd0);
    wr(2'd0, 8'h33); wr(2'd1, 8'hFF);
    check("R10 err set", {31'h0, index_err}, 32'd1);
    check("R10 cursor_hi kept", {24'h0, cursor_hi}, 32'h3C);
    check("R10 cursor_lo kept", {24'h0, cursor_lo}, 32'hC3);
    check("R10 dbuf kept", {24'h0, dbuf_ctrl}, 32'h5A);
    check("R10 div kept", {27'h0, clk_div}, 32'd2);
    wr(2'd0, 8'h10); wr(2'd1, 8'h3C);
    check("R10 err sticky", {31'h0, index_err}, 32'd1);
  endtask

  task automatic t_cursor;
    wr(2'd0, 8'h80);
    wr(2'd2, 8'h12); wr(2'd2, 8'h34);
    wr(2'd3, 8'hEE);
    check("R11 addr kept", {24'h0, dac_addr}, 32'h80);
    check("R11 cursor_hi kept", {24'h0, cursor_hi}, 32'h3C);
    check("R11 dbuf kept", {24'h0, dbuf_ctrl}, 32'h5A);
    wr(2'd2, 8'h56);
    entry("R11 phase kept", 8'h80, 32'hFF123456);
    check("R11 addr step", {24'h0, dac_addr}, 32'h81);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_port = 2'd0; wr_data = 8'h00; rd_index = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_palette();
    t_restart();
    t_wrap();
    t_ireg();
    t_depth();
    t_bad_depth();
    t_bad_index();
    t_cursor();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule